// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block passively observes the clock and data wires of an open-drain two-wire serial bus (I2C style) and turns their activity into clean, system-clock-aligned events. Both wires first pass through a synchronizer. The block then compares each synchronized sample with the one before it. When data moves while the clock wire is high, the block reports a bus condition. It reports a falling data edge as a start, or as a repeated start if the bus is already busy. It reports a rising data edge as a stop.

The block holds a busy flag from a start until the next stop. It counts clock-high pulses within each nine-pulse frame (eight data bits, most significant first, then one acknowledge) and strobes when a frame completes. It also flags a start or stop that falls inside a data slot of a frame, because data must stay constant while the clock is high. The block has only inputs on the bus side and never drives either wire. A protocol engine, a bus analyser or a watchdog can use it as its front end.

Top module: `bus_cond_monitor`

## Requirements
- R1: After reset, busBusy is 0, bitIdx is 0 and no pulse output (startPulse, reStartPulse, stopPulse, frameDone, sdaViolation) is high.
- R2: A data fall while the clock is high and busBusy is 0 gives one startPulse and sets busBusy.
- R3: A data fall while the clock is high and busBusy is 1 gives one reStartPulse and no startPulse, and busBusy stays 1.
- R4: A data rise while the clock is high gives one stopPulse and clears busBusy, which leaves both wires high and the bus idle.
- R5: A data change while the clock is low gives no start, repeated start or stop pulse.
- R6: While busy, bitIdx counts clock rising edges within a frame, 1 through 8 and then 0 on the ninth edge. On that ninth edge frameDone pulses for one cycle.
- R7: Clock edges while the bus is idle leave bitIdx at 0 and raise no frameDone.
- R8: Any start, repeated start or stop returns bitIdx to 0.
- R9: sdaViolation pulses together with the reStartPulse or stopPulse of a condition seen while busy and while bitIdx is 2 or more. A condition inside the first clock-high slot of a frame (bitIdx 0 or 1) is legal.
- R10: Every pulse output is high for exactly one system clock. At most one of startPulse, reStartPulse and stopPulse is high in any cycle. A wire change appears at the outputs SYNC_STAGES+1 clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock wire level, asynchronous |
| sdaIn | input | 1 | Bus data wire level, asynchronous |
| startPulse | output | 1 | One-cycle pulse on a start from idle |
| reStartPulse | output | 1 | One-cycle pulse on a start while busy |
| stopPulse | output | 1 | One-cycle pulse on a stop |
| busBusy | output | 1 | High from a start until the next stop |
| bitIdx | output | IDX_W | Clock-high pulses seen in the current frame |
| frameDone | output | 1 | One-cycle pulse when a nine-pulse frame ends |
| sdaViolation | output | 1 | One-cycle pulse on a condition inside a data slot |

## Verification
The bench builds the block with its defaults, a two-stage synchronizer and a nine-pulse frame. This keeps the frame short enough to drive every bit position by hand. It sends full frames with several data patterns and checks bitIdx after every clock pulse. It then sweeps a stop across each of the nine positions in a frame, so every legal and illegal position of a condition is exercised. One start is measured edge by edge to pin down the latency of three clock edges.

// File: rtl/buscond_pkg.sv
package buscond_pkg;
  // events seen on the synchronized wires, datapath -> control
  typedef struct packed {
    logic startCond;
    logic stopCond;
    logic sclRise;
    logic cntPastFirst;
  } busEvents_t;

  // counter strobes, control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic advCnt;
  } cntStrobes_t;
endpackage

// File: rtl/buscond_dp.sv
module buscond_dp
  import buscond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9,
  parameter int IDX_W       = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  cntStrobes_t      strobes,
  output busEvents_t       events,
  output logic [IDX_W-1:0] bitIdx,
  output logic             frameDone
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] FIRST_DATA_IDX = IDX_W'(2);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclQ, sdaQ;
  logic [IDX_W-1:0] cnt;
  logic frameDoneQ;

  // synchronizer chains for both wires
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  // previous synchronized sample for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
    end
  end

  always_comb begin
    events.startCond    = sclQ & sclS & sdaQ & ~sdaS;
    events.stopCond     = sclQ & sclS & ~sdaQ & sdaS;
    events.sclRise      = ~sclQ & sclS;
    events.cntPastFirst = (cnt >= FIRST_DATA_IDX);
  end

  // bit counter within a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      frameDoneQ <= 1'b0;
    end else begin
      frameDoneQ <= 1'b0;
      if (strobes.clrCnt) begin
        cnt <= '0;
      end else if (strobes.advCnt) begin
        if (cnt == LAST_IDX) begin
          cnt        <= '0;
          frameDoneQ <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign bitIdx    = cnt;
  assign frameDone = frameDoneQ;

  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST_IDX);
  assert_frame_wraps_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameDoneQ |-> (cnt == '0));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrCnt && !strobes.advCnt) |=> $stable(cnt));
  assert_clear_on_cond_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCnt |=> (cnt == '0) && !frameDoneQ);
endmodule

// File: rtl/buscond_ctrl.sv
module buscond_ctrl
  import buscond_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvents_t  events,
  output cntStrobes_t strobes,
  output logic        busBusy,
  output logic        startPulse,
  output logic        reStartPulse,
  output logic        stopPulse,
  output logic        sdaViolation
);
  logic busyQ, startQ, reStartQ, stopQ, violQ;
  logic anyCond;

  assign anyCond = events.startCond | events.stopCond;

  always_comb begin
    strobes.clrCnt = anyCond;
    strobes.advCnt = events.sclRise & busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      startQ   <= 1'b0;
      reStartQ <= 1'b0;
      stopQ    <= 1'b0;
      violQ    <= 1'b0;
    end else begin
      startQ   <= events.startCond & ~busyQ;
      reStartQ <= events.startCond & busyQ;
      stopQ    <= events.stopCond;
      violQ    <= anyCond & busyQ & events.cntPastFirst;
      if (events.startCond)     busyQ <= 1'b1;
      else if (events.stopCond) busyQ <= 1'b0;
    end
  end

  assign busBusy      = busyQ;
  assign startPulse   = startQ;
  assign reStartPulse = reStartQ;
  assign stopPulse    = stopQ;
  assign sdaViolation = violQ;

  assert_one_cond_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startQ, reStartQ, stopQ}));
  assert_start_pulse_short_R10: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> busyQ && !$past(busyQ));
  assert_restart_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    reStartQ |-> busyQ && $past(busyQ));
  assert_stop_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopQ |-> !busyQ);
  assert_viol_with_cond_R9: assert property (@(posedge clk) disable iff (!rstN)
    violQ |-> (reStartQ || stopQ));
endmodule

// File: rtl/bus_cond_monitor.sv
module bus_cond_monitor
  import buscond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9,
  parameter int IDX_W       = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             startPulse,
  output logic             reStartPulse,
  output logic             stopPulse,
  output logic             busBusy,
  output logic [IDX_W-1:0] bitIdx,
  output logic             frameDone,
  output logic             sdaViolation
);
  busEvents_t  events;
  cntStrobes_t strobes;

  buscond_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS),
    .IDX_W      (IDX_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .strobes  (strobes),
    .events   (events),
    .bitIdx   (bitIdx),
    .frameDone(frameDone)
  );

  buscond_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .events      (events),
    .strobes     (strobes),
    .busBusy     (busBusy),
    .startPulse  (startPulse),
    .reStartPulse(reStartPulse),
    .stopPulse   (stopPulse),
    .sdaViolation(sdaViolation)
  );
endmodule

// File: tb/test_bus_cond_monitor.sv
module test_bus_cond_monitor;
  localparam int SYNC = 2;
  localparam int FB   = 9;
  localparam int IW   = $clog2(FB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic startPulse, reStartPulse, stopPulse, busBusy, frameDone, sdaViolation;
  logic [IW-1:0] bitIdx;

  int nChecks = 0;
  int nErrors = 0;
  int nStart = 0, nRe = 0, nStop = 0, nFrame = 0, nViol = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cond_monitor #(.SYNC_STAGES(SYNC), .FRAME_BITS(FB)) i_bus_cond_monitor (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda),
    .startPulse(startPulse), .reStartPulse(reStartPulse), .stopPulse(stopPulse),
    .busBusy(busBusy), .bitIdx(bitIdx), .frameDone(frameDone),
    .sdaViolation(sdaViolation)
  );

  always @(negedge clk) begin
    if (rstN) begin
      nStart += int'(startPulse);
      nRe    += int'(reStartPulse);
      nStop  += int'(stopPulse);
      nFrame += int'(frameDone);
      nViol  += int'(sdaViolation);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic d);
    scl = c;
    sda = d;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendStart();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic sendBit(input logic b);
    drive(1'b0, b);
    drive(1'b1, b);
    drive(1'b0, b);
  endtask

  task automatic sendStop();
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
  endtask

  task automatic sendRestart();
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int s0, r0, p0, f0, v0;
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'h00; pats[3] = 8'hFF;

    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 busy", int'(busBusy), 0);
    chk("R1 bitIdx", int'(bitIdx), 0);
    chk("R1 pulses", int'({startPulse, reStartPulse, stopPulse, frameDone, sdaViolation}), 0);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle after release", int'(busBusy), 0);

    // R10 latency and width, R2 start from idle
    sda = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 no early start", int'(startPulse), 0);
    @(negedge clk);
    chk("R10 R2 start after three edges", int'(startPulse), 1);
    chk("R2 busy set", int'(busBusy), 1);
    chk("R2 not restart", int'(reStartPulse), 0);
    @(negedge clk);
    chk("R10 start one cycle", int'(startPulse), 0);
    repeat (4) @(negedge clk);
    drive(1'b0, 1'b0);

    // R4 stop in first slot, legal
    p0 = nStop; v0 = nViol;
    sendStop();
    chk("R4 stop pulse", nStop - p0, 1);
    chk("R4 busy cleared", int'(busBusy), 0);
    chk("R8 idx after stop", int'(bitIdx), 0);
    chk("R9 no viol first slot", nViol - v0, 0);

    // R7: clock toggles while idle
    f0 = nFrame; s0 = nStart; p0 = nStop;
    for (int i = 0; i < 10; i++) begin
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b1);
      chk("R7 idle idx", int'(bitIdx), 0);
    end
    chk("R7 no frame when idle", nFrame - f0, 0);
    chk("R7 no conditions when idle", (nStart - s0) + (nStop - p0), 0);

    // R6, R5: full frames with several data patterns
    foreach (pats[j]) begin
      s0 = nStart; r0 = nRe; p0 = nStop; f0 = nFrame;
      sendStart();
      chk("R2 start per frame", nStart - s0, 1);
      for (int k = 0; k < FB; k++) begin
        sendBit((k < 8) ? pats[j][7-k] : 1'b0);
        chk("R6 bit index", int'(bitIdx), (k + 1) % FB);
        chk("R6 frame strobe count", nFrame - f0, (k == FB - 1) ? 1 : 0);
      end
      chk("R5 no stray conditions", (nStart - s0 - 1) + (nRe - r0) + (nStop - p0), 0);
      chk("R6 busy during frame", int'(busBusy), 1);
      sendStop();
      chk("R4 stop after frame", nStop - p0, 1);
    end

    // R3, R8, R9: repeated starts
    s0 = nStart; r0 = nRe; v0 = nViol;
    sendStart();
    for (int k = 0; k < FB; k++) sendBit(k[0]);
    sendRestart();
    chk("R3 restart pulse", nRe - r0, 1);
    chk("R3 no start pulse", nStart - s0, 1);
    chk("R3 busy kept", int'(busBusy), 1);
    chk("R8 idx after restart", int'(bitIdx), 0);
    chk("R9 legal restart", nViol - v0, 0);
    for (int k = 0; k < 4; k++) sendBit(1'b1);
    chk("R6 idx mid frame", int'(bitIdx), 4);
    sendRestart();
    chk("R9 mid-frame restart flagged", nViol - v0, 1);
    chk("R3 second restart", nRe - r0, 2);
    chk("R8 idx cleared", int'(bitIdx), 0);
    p0 = nStop;
    sendStop();
    chk("R4 stop ends restarted frame", nStop - p0, 1);

    // R9: stop swept across every frame position
    for (int p = 0; p < FB; p++) begin
      v0 = nViol; p0 = nStop; f0 = nFrame;
      sendStart();
      for (int k = 0; k < p; k++) sendBit(1'b0);
      sendStop();
      chk("R9 violation at position", nViol - v0, (((p + 1) % FB) >= 2) ? 1 : 0);
      chk("R4 stop in sweep", nStop - p0, 1);
      chk("R6 frame in sweep", nFrame - f0, (p == FB - 1) ? 1 : 0);
      chk("R4 idle in sweep", int'(busBusy), 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule